// File: doc/BRIEF.md
# Receive Queue Steering Table

This block turns a 32-bit flow hash into a receive queue number. The seven low bits of the hash pick one of 128 table slots. Each slot holds a 3-bit queue number, so traffic can be spread over up to eight queues. A hash presented with its valid strobe comes back as a queue number with a valid strobe one clock later.

Software programs the table through a 32-bit word port. Each word packs four slots, one per byte lane. Per-lane write strobes let a single slot change without touching its neighbours. Reads return all four slots of a word.

A built-in fill engine can load the whole table round-robin over the number of active queues, at one slot per clock. A sticky flag is set by any explicit table write. While that flag is set, the engine leaves the table alone. A port-stop pulse clears the flag.

Top module: `rxq_steer_table`

## Requirements
- R1: After reset the table holds zero in every slot, q_vld, fill_busy and fill_done are low, and every word reads back as zero.
- R2: hash_vld high at clock t gives q_vld high at t+1, with q_idx equal to the slot that hash[6:0] selects. Hash bits above bit 6 have no effect. hash_vld low at t gives q_vld low at t+1.
- R3: Slot n lives in word n>>2, byte lane n&3. Its queue number is taken from and returned in bits [8*(n&3)+2 : 8*(n&3)] of that word.
- R4: reg_wr with reg_be updates only the lanes whose strobe bit is set (bit k selects lane k). Lanes whose strobe is clear keep their value.
- R5: reg_rd at clock t loads reg_rdata at t+1 with the four slots of word reg_addr. Bits [7:3] of every lane read as zero. reg_rdata holds its value until the next read.
- R6: fill_start, sampled while the engine is idle and the flag is clear, makes fill_busy high for exactly 128 cycles. During that time slot i is written with i mod N, where N is active_queues, with 0 treated as 1 and values above 8 treated as 8. fill_done pulses for one cycle right after fill_busy falls.
- R7: Any reg_wr with at least one strobe set makes the updated flag sticky. A fill_start that arrives while the flag is set changes no slot and never raises fill_busy. fill_done pulses on the next cycle.
- R8: port_stop clears the updated flag, so a later fill_start runs a full fill. A write in the same cycle as port_stop still sets the flag.
- R9: When a register write and the fill engine target the same slot in the same cycle, the register write value is stored.
- R10: fill_start while fill_busy is high is ignored. The running fill keeps its queue count and finishes on its original schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hash_vld | input | 1 | Hash strobe |
| hash | input | 32 | Flow hash; low 7 bits index the table |
| q_vld | output | 1 | Queue result valid, one cycle after hash_vld |
| q_idx | output | 3 | Selected receive queue |
| reg_wr | input | 1 | Table word write |
| reg_rd | input | 1 | Table word read |
| reg_addr | input | 5 | Word address (four slots per word) |
| reg_be | input | 4 | Per-lane write strobes |
| reg_wdata | input | 32 | Write data, one slot per byte lane |
| reg_rdata | output | 32 | Read data, registered |
| fill_start | input | 1 | Start round-robin fill |
| active_queues | input | 4 | Queue count for the fill |
| port_stop | input | 1 | Clears the updated flag |
| fill_busy | output | 1 | Fill in progress |
| fill_done | output | 1 | One-cycle fill completion pulse |

## Verification
The bench targets these corner cases:

- **Partial-strobe writes.** A design that ignored the strobes would clobber neighbouring slots.
- **Stray high bits.** High hash bits and high data bits within a lane are set on purpose. A wrong index slice or padding would return a different slot or nonzero pad bits.
- **Fill skipping.** Fill requests are made with the updated flag both set and cleared. A design that ignored the flag would overwrite hand-written slots, and one that never cleared it would never fill again.
- **Fill edge cases.** Queue counts of 0, 3, 5 and 11 are used, along with a second start pulse mid-fill. A write is also timed to hit the same slot in the very cycle the fill engine writes it, which exposes wrong clamping, restart-on-busy and reversed write priority.

// File: rtl/rxq_steer_table.sv
module rxq_steer_table #(
  parameter int ENTRIES = 128,
  parameter int QW      = 3,
  parameter int DW      = 32,
  parameter int HW      = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   hash_vld,
  input  logic [HW-1:0]                          hash,
  output logic                                   q_vld,
  output logic [QW-1:0]                          q_idx,
  input  logic                                   reg_wr,
  input  logic                                   reg_rd,
  input  logic [$clog2(ENTRIES)-$clog2(DW/8)-1:0] reg_addr,
  input  logic [DW/8-1:0]                        reg_be,
  input  logic [DW-1:0]                          reg_wdata,
  output logic [DW-1:0]                          reg_rdata,
  input  logic                                   fill_start,
  input  logic [QW:0]                            active_queues,
  input  logic                                   port_stop,
  output logic                                   fill_busy,
  output logic                                   fill_done
);
  localparam int IDXW  = $clog2(ENTRIES);
  localparam int LANES = DW / 8;
  localparam int LW    = $clog2(LANES);
  localparam int AW    = IDXW - LW;
  localparam int NQW   = QW + 1;
  localparam int MAXQ  = 1 << QW;

  logic [QW-1:0]      tbl [ENTRIES];
  logic [ENTRIES-1:0] wr_hit;
  logic [DW-1:0]      rd_word;
  logic               upd;
  logic [IDXW-1:0]    fill_idx;
  logic [QW-1:0]      fill_q;
  logic [NQW-1:0]     fill_n;
  logic [NQW-1:0]     nq_req;

  wire wr_any   = reg_wr && (|reg_be);
  wire fill_go  = fill_start && !fill_busy;
  wire q_wrap   = (NQW'(fill_q) + NQW'(1)) == fill_n;

  assign nq_req = (active_queues == '0)              ? NQW'(1) :
                  (active_queues > NQW'(MAXQ))       ? NQW'(MAXQ) :
                  active_queues;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++)
      wr_hit[e] = reg_wr && (reg_addr == AW'(e >> LW)) && reg_be[e % LANES];
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      rd_word[8*l +: 8] = 8'(tbl[{reg_addr, LW'(l)}]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) tbl[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wr_hit[e])
          tbl[e] <= reg_wdata[8*(e % LANES) +: QW];
        else if (fill_busy && fill_idx == IDXW'(e))
          tbl[e] <= fill_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld     <= 1'b0;
      q_idx     <= '0;
      reg_rdata <= '0;
    end else begin
      q_vld <= hash_vld;
      if (hash_vld) q_idx <= tbl[hash[IDXW-1:0]];
      if (reg_rd) reg_rdata <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upd <= 1'b0;
    else if (wr_any) upd <= 1'b1;
    else if (port_stop) upd <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_busy <= 1'b0;
      fill_done <= 1'b0;
      fill_idx  <= '0;
      fill_q    <= '0;
      fill_n    <= NQW'(1);
    end else begin
      fill_done <= 1'b0;
      if (fill_busy) begin
        fill_idx <= fill_idx + IDXW'(1);
        fill_q   <= q_wrap ? '0 : fill_q + QW'(1);
        if (fill_idx == IDXW'(ENTRIES - 1)) begin
          fill_busy <= 1'b0;
          fill_done <= 1'b1;
        end
      end else if (fill_go) begin
        if (upd) begin
          fill_done <= 1'b1;
        end else begin
          fill_busy <= 1'b1;
          fill_idx  <= '0;
          fill_q    <= '0;
          fill_n    <= nq_req;
        end
      end
    end
  end
endmodule

// File: rtl/rxq_steer_table_chk.sv
module rxq_steer_table_chk #(
  parameter int DW = 32,
  parameter int QW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hash_vld,
  input logic          q_vld,
  input logic [DW-1:0] reg_rdata,
  input logic          reg_wr,
  input logic [DW/8-1:0] reg_be,
  input logic          port_stop,
  input logic          fill_start,
  input logic          fill_busy,
  input logic          fill_done,
  input logic          upd
);
  function automatic logic [DW-1:0] pad_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int l = 0; l < DW/8; l++) m[8*l+QW +: 8-QW] = '1;
    return m;
  endfunction
  localparam logic [DW-1:0] PADMASK = pad_mask();

  assert_lookup_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hash_vld |=> q_vld);
  assert_lookup_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hash_vld |=> !q_vld);
  assert_read_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & PADMASK) == '0);
  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fill_busy) |-> fill_done);
  assert_skip_when_updated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_start && !fill_busy && upd) |=> (fill_done && !fill_busy));
  assert_flag_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (|reg_be)) |=> upd);
  assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_stop && !(reg_wr && (|reg_be))) |=> !upd);
  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_busy && !fill_done && fill_start) |=> (fill_busy || fill_done));
endmodule

bind rxq_steer_table rxq_steer_table_chk #(.DW(DW), .QW(QW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hash_vld(hash_vld), .q_vld(q_vld),
  .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_be(reg_be),
  .port_stop(port_stop), .fill_start(fill_start), .fill_busy(fill_busy),
  .fill_done(fill_done), .upd(upd)
);

// File: tb/rxq_steer_table_tb_top.sv
module rxq_steer_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hash_vld;
  logic [31:0] hash;
  logic        q_vld;
  logic [2:0]  q_idx;
  logic        reg_wr, reg_rd;
  logic [4:0]  reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        fill_start;
  logic [3:0]  active_queues;
  logic        port_stop;
  logic        fill_busy, fill_done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  logic [2:0] exp_t [128];
  bit upd_m;

  always #5 clk = ~clk;

  rxq_steer_table dut_i (
    .clk(clk), .rst_n(rst_n), .hash_vld(hash_vld), .hash(hash),
    .q_vld(q_vld), .q_idx(q_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fill_start(fill_start),
    .active_queues(active_queues), .port_stop(port_stop),
    .fill_busy(fill_busy), .fill_done(fill_done)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clamp_n(logic [3:0] aq);
    if (aq == 0) return 1;
    if (aq > 8) return 8;
    return int'(aq);
  endfunction

  function automatic logic [31:0] word_of(int a);
    logic [31:0] w;
    for (int l = 0; l < 4; l++) w[8*l +: 8] = {5'b0, exp_t[4*a + l]};
    return w;
  endfunction

  task automatic reg_write(int a, logic [31:0] d, logic [3:0] be);
    reg_wr = 1; reg_addr = 5'(a); reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 0;
    for (int l = 0; l < 4; l++) if (be[l]) exp_t[4*a + l] = d[8*l +: 3];
    if (be != 0) upd_m = 1;
  endtask

  task automatic reg_read(int a, string req);
    reg_rd = 1; reg_addr = 5'(a);
    @(negedge clk);
    reg_rd = 0;
    chk(reg_rdata == word_of(a), req, reg_rdata, word_of(a));
  endtask

  task automatic lookup(logic [31:0] h);
    hash_vld = 1; hash = h;
    @(negedge clk);
    hash_vld = 0;
    chk(q_vld === 1'b1, "R2 valid", 32'(q_vld), 32'd1);
    chk(q_idx == exp_t[h[6:0]], "R2 R3 lookup", 32'(q_idx), 32'(exp_t[h[6:0]]));
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < 32; a++) reg_read(a, req);
  endtask

  // pulse_at / coll_at: loop cycle at which to inject a second start or a colliding write (-1 none)
  task automatic fill_run(logic [3:0] aq, int pulse_at, int coll_at, logic [2:0] coll_v);
    int n;
    int cnt;
    bit skip;
    n = clamp_n(aq);
    skip = upd_m;
    active_queues = aq; fill_start = 1;
    @(negedge clk);
    fill_start = 0;
    if (skip) begin
      chk(fill_busy == 0 && fill_done == 1, "R7 skip",
          {30'b0, fill_busy, fill_done}, 32'd1);
      @(negedge clk);
      return;
    end
    cnt = 0;
    while (fill_busy && cnt < 300) begin
      reg_wr = 0; fill_start = 0;
      if (cnt == coll_at) begin
        reg_wr = 1; reg_addr = 5'(coll_at >> 2); reg_be = 4'(1 << (coll_at % 4));
        reg_wdata = {4{5'b11111, coll_v}};
      end
      if (cnt == pulse_at) begin
        fill_start = 1; active_queues = 4'd2;
      end
      cnt++;
      @(negedge clk);
    end
    reg_wr = 0; fill_start = 0;
    chk(cnt == 128, "R6 busy length", 32'(cnt), 32'd128);
    chk(fill_done == 1, "R6 done pulse", 32'(fill_done), 32'd1);
    for (int i = 0; i < 128; i++) exp_t[i] = 3'(i % n);
    if (coll_at >= 0) begin
      exp_t[coll_at] = coll_v;
      upd_m = 1;
    end
    @(negedge clk);
    chk(fill_done == 0, "R6 done single", 32'(fill_done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; hash_vld = 0; hash = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0;
    reg_be = 0; reg_wdata = 0; fill_start = 0; active_queues = 4'd1; port_stop = 0;
    for (int i = 0; i < 128; i++) exp_t[i] = 0;
    upd_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(q_vld == 0, "R1 q_vld", 32'(q_vld), 0);
    chk(fill_busy == 0 && fill_done == 0, "R1 fill idle", {30'b0, fill_busy, fill_done}, 0);
    chk(reg_rdata == 0, "R1 rdata", reg_rdata, 0);
    reg_read(0, "R1 word0");
    reg_read(31, "R1 word31");

    // R3 R5 full word write with pad bits set
    reg_write(5, 32'hFFFF_FFFF, 4'hF);
    reg_read(5, "R3 R5 full word");
    // R4 partial strobes
    reg_write(5, 32'h0203_0405, 4'b0101);
    reg_read(5, "R4 partial strobes");
    chk(word_of(5) == 32'h0703_0705, "R4 model word", word_of(5), 32'h0703_0705);
    // R2 upper hash bits ignored
    lookup(32'hABCD_E015);
    lookup(32'h0000_0016);
    @(negedge clk);
    chk(q_vld == 0, "R2 idle", 32'(q_vld), 0);

    // R7 fill skipped while flag set
    fill_run(4'd3, -1, -1, 3'd0);
    read_all("R7 table unchanged");

    // R8 port stop then full fill, N=3
    port_stop = 1; @(negedge clk); port_stop = 0;
    upd_m = 0;
    fill_run(4'd3, -1, -1, 3'd0);
    read_all("R6 R8 fill n3");
    lookup(32'h0000_007F);

    // R6 clamping
    fill_run(4'd0, -1, -1, 3'd0);
    read_all("R6 fill n0");
    fill_run(4'd11, -1, -1, 3'd0);
    read_all("R6 fill n11");

    // R10 restart ignored
    fill_run(4'd5, 20, -1, 3'd0);
    read_all("R10 fill n5");

    // R9 collision on slot 40
    fill_run(4'd6, -1, 40, 3'd7);
    read_all("R9 collision");
    // flag now set by the colliding write -> next fill skipped (R7)
    fill_run(4'd2, -1, -1, 3'd0);
    reg_read(10, "R7 after collision");

    // R8 write with simultaneous stop keeps flag
    port_stop = 1; reg_wr = 1; reg_addr = 5'd3; reg_be = 4'b0010; reg_wdata = 32'h0000_0600;
    @(negedge clk);
    port_stop = 0; reg_wr = 0;
    exp_t[13] = 3'd6; upd_m = 1;
    fill_run(4'd4, -1, -1, 3'd0);
    reg_read(3, "R8 write wins over stop");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int k;
      k = int'($urandom_range(0, 2));
      if (k == 0) reg_write(int'($urandom_range(0, 31)), $urandom(), 4'($urandom()));
      else if (k == 1) reg_read(int'($urandom_range(0, 31)), "R4 R5 random read");
      else lookup($urandom());
    end
    port_stop = 1; @(negedge clk); port_stop = 0; upd_m = 0;
    fill_run(4'd7, -1, -1, 3'd0);
    for (int it = 0; it < 60; it++) lookup($urandom());

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule